// File: doc/BRIEF.md
# Rejection-Sampled Dice Value Generator

This block produces fair dice values from 1 to 6. A 32-bit shift register with XOR feedback (Fibonacci form) supplies one pseudorandom bit per cycle while a roll is in progress. The bits are gathered three at a time into a candidate. A candidate of 0 or 7 is thrown away, and the next three fresh bits are gathered. An accepted candidate appears on the value output together with a valid strobe that lasts one cycle. Because whole candidates are rejected and no modulo is taken, every face is equally likely.

A user asks for a roll with a request pulse and waits for the strobe. The shift register can be seeded at any time. A seed load cancels a roll that is in progress. The register advances only while a roll is drawing bits, so the sequence of faces after a given seed depends only on that seed and not on how long the block sits idle between rolls.

Top module: `dice_roll_gen`

## Requirements
- R1: During each drawing cycle the register takes one step: the new bit is the XOR of state bits 31, 21, 1 and 0; it enters at bit 0 while the other bits move up one place. The register holds its value while no roll is in progress.
- R2: A seed load writes `seed_i` into the register on the next edge. An all-zero seed is replaced by 32'hACE1_2468, so the register never holds zero.
- R3: A candidate is built from three consecutive new bits, and the first bit drawn is the most significant. Each value that is presented lies in 1 to 6.
- R4: A candidate of 0 or 7 is dropped, and the block gathers three more fresh bits with no pause. Bits are never shared between candidates.
- R5: `valid_o` is high for exactly one cycle for each completed roll. It rises on the edge that completes the accepted candidate, which is at least three edges after the edge that accepts the request. It is never high while no roll is in progress.
- R6: `value_o` changes only when `valid_o` is high, and it holds the last accepted face between strobes. After reset it reads 0 and `valid_o` is low.
- R7: A roll request that arrives while a roll is in progress is ignored. It changes neither the timing nor the value of that roll, and it does not start a second roll.
- R8: A seed load cancels any roll in progress with no strobe. If a seed load and a roll request fall on the same edge, the seed load wins and the request is dropped.
- R9: Reset loads 32'hACE1_2468 into the register and leaves the block idle. The reset is applied asynchronously and released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| roll_req_i | input | 1 | Starts a roll when the block is idle |
| seed_load_i | input | 1 | Loads a new seed and cancels any roll in progress |
| seed_i | input | 32 | Seed value; zero is replaced by the default constant |
| value_o | output | 3 | Last accepted face, from 1 to 6 |
| valid_o | output | 1 | One-cycle strobe marking a new face |

## Verification
Two functions can fall on the same edge: a seed load and a roll request, either both at once while idle or with the load landing part-way through a draw. The bench provokes both cases. It then judges by the outputs that no strobe appears, that the register stopped at the new seed without advancing, and that the next roll gives exactly the face a reference register started from that seed predicts, after the predicted number of cycles. Random seeds, idle gaps and extra requests issued during a roll are mixed with these directed collisions.

// File: rtl/dice_roll_pkg.sv
`timescale 1ns/1ps
package dice_roll_pkg;
  localparam int unsigned LFSR_W = 32;
  localparam int unsigned GRP_W  = 3;
  localparam logic [LFSR_W-1:0] SEED_DEFAULT = 32'hACE1_2468;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_DRAW = 1'b1
  } draw_state_e;
endpackage

// File: rtl/dice_rst_sync.sv
`timescale 1ns/1ps
module dice_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/dice_lfsr_core.sv
`timescale 1ns/1ps
module dice_lfsr_core #(
  parameter int unsigned W     = 32,
  parameter int unsigned TAP_A = 32,
  parameter int unsigned TAP_B = 22,
  parameter int unsigned TAP_C = 2,
  parameter int unsigned TAP_D = 1,
  parameter logic [W-1:0] SEED = 32'hACE1_2468
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic         bit_o,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;
  logic         fb;

  assign fb = state_q[TAP_A-1] ^ state_q[TAP_B-1] ^ state_q[TAP_C-1] ^ state_q[TAP_D-1];

  always_comb begin
    state_d = state_q;
    if (load_i) begin
      state_d = (load_val_i == '0) ? SEED : load_val_i;
    end else if (step_i) begin
      state_d = {state_q[W-2:0], fb};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign bit_o   = fb;
  assign state_o = state_q;
endmodule

// File: rtl/dice_sampler.sv
`timescale 1ns/1ps
module dice_sampler
  import dice_roll_pkg::*;
#(
  parameter int unsigned GW = GRP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          abort_i,
  input  logic          bit_i,
  output logic          step_o,
  output logic          busy_o,
  output logic [GW-1:0] value_o,
  output logic          valid_o
);
  localparam int unsigned CW = (GW > 1) ? $clog2(GW) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(GW - 1);
  localparam logic [GW-1:0] ALL_ONES = '1;

  draw_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [GW-1:0] cand_q, cand_d;
  logic [GW-1:0] value_q, value_d;
  logic          valid_q, valid_d;
  logic [GW-1:0] full;

  assign full = {cand_q[GW-2:0], bit_i};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cand_d  = cand_q;
    value_d = value_q;
    valid_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && !abort_i) begin
          state_d = ST_DRAW;
          cnt_d   = '0;
        end
      end
      ST_DRAW: begin
        if (abort_i) begin
          state_d = ST_IDLE;
        end else begin
          cand_d = full;
          if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
            if (full != '0 && full != ALL_ONES) begin
              value_d = full;
              valid_d = 1'b1;
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cand_q  <= '0;
      value_q <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cand_q  <= cand_d;
      value_q <= value_d;
      valid_q <= valid_d;
    end
  end

  assign step_o  = (state_q == ST_DRAW) && !abort_i;
  assign busy_o  = (state_q == ST_DRAW);
  assign value_o = value_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dice_roll_gen.sv
`timescale 1ns/1ps
module dice_roll_gen
  import dice_roll_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              roll_req_i,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [GRP_W-1:0]  value_o,
  output logic              valid_o
);
  logic              rst_sync_n;
  logic              step;
  logic              busy;
  logic              lfsr_bit;
  logic [LFSR_W-1:0] lfsr_state;

  dice_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  dice_lfsr_core #(
    .W     (LFSR_W),
    .TAP_A (32),
    .TAP_B (22),
    .TAP_C (2),
    .TAP_D (1),
    .SEED  (SEED_DEFAULT)
  ) u_lfsr (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .load_i     (seed_load_i),
    .load_val_i (seed_i),
    .step_i     (step),
    .bit_o      (lfsr_bit),
    .state_o    (lfsr_state)
  );

  dice_sampler #(.GW(GRP_W)) u_samp (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .req_i   (roll_req_i),
    .abort_i (seed_load_i),
    .bit_i   (lfsr_bit),
    .step_o  (step),
    .busy_o  (busy),
    .value_o (value_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/dice_roll_chk.sv
`timescale 1ns/1ps
module dice_roll_chk
  import dice_roll_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              seed_load_i,
  input logic [GRP_W-1:0]  value_o,
  input logic              valid_o,
  input logic [LFSR_W-1:0] lfsr_state,
  input logic              busy
);
  AST_FACE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (value_o >= 3'd1 && value_o <= 3'd6)); // R3

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5

  AST_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> !valid_o); // R5

  AST_FACE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(value_o)); // R6

  AST_STATE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_state != '0); // R2

  AST_LOAD_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> !valid_o); // R8
endmodule

bind dice_roll_gen dice_roll_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .seed_load_i (seed_load_i),
  .value_o     (value_o),
  .valid_o     (valid_o),
  .lfsr_state  (lfsr_state),
  .busy        (busy)
);

// File: tb/dice_roll_gen_tb_top.sv
`timescale 1ns/1ps
module dice_roll_gen_tb_top;
  localparam logic [31:0] DEF_SEED = 32'hACE1_2468;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        ld = 1'b0;
  logic [31:0] seed = '0;
  logic [2:0]  val;
  logic        vld;

  int checks = 0;
  int errors = 0;
  int hist [8];
  logic [31:0] m_s;

  always #2.5 clk = ~clk;

  dice_roll_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .roll_req_i  (req),
    .seed_load_i (ld),
    .seed_i      (seed),
    .value_o     (val),
    .valid_o     (vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic fbit(input logic [31:0] s);
    return s[31] ^ s[21] ^ s[1] ^ s[0];
  endfunction

  // One roll, checked against a reference register (R1 R3 R4 R5 R7)
  task automatic roll(input string tag, input bit extra_req);
    logic [31:0] s;
    logic [2:0]  c;
    int          n;
    bit          early;
    s = m_s;
    n = 0;
    do begin
      c = '0;
      for (int i = 0; i < 3; i++) begin
        c = {c[1:0], fbit(s)};
        s = {s[30:0], fbit(s)};
        n++;
      end
    end while (c == 3'd0 || c == 3'd7);
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    early = 1'b0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (extra_req && k == 1) req = 1'b1;
      if (k == 2) req = 1'b0;
      if (k < n && vld) early = 1'b1;
      if (k == n) begin
        chk(vld == 1'b1, {tag, " R5 strobe at predicted cycle"}, vld, 1);
        chk(val == c, {tag, (n > 3) ? " R4 value after reject" : " R1/R3 value"}, val, c);
        hist[val]++;
      end
    end
    chk(!early, {tag, " R5 no early strobe"}, early, 0);
    @(negedge clk);
    chk(vld == 1'b0, {tag, extra_req ? " R7 no second roll" : " R5 single-cycle strobe"}, vld, 0);
    m_s = s;
  endtask

  task automatic load(input logic [31:0] v, input bit with_req);
    @(negedge clk);
    ld = 1'b1; seed = v; req = with_req;
    @(negedge clk);
    ld = 1'b0; req = 1'b0;
    m_s = (v == '0) ? DEF_SEED : v;
  endtask

  task automatic quiet(input int cyc, input string tag);
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (vld) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0]  held;
    int unsigned r;
    for (int i = 0; i < 8; i++) hist[i] = 0;
    r = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(vld == 1'b0, "R9 valid low in reset", vld, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(vld == 1'b0, "R6 valid low after reset", vld, 0);
    chk(val == 3'd0, "R6 value zero after reset", val, 0);

    // R9: first roll uses the default seed
    m_s = DEF_SEED;
    roll("R9 default seed", 1'b0);

    // R6: value holds while idle
    held = val;
    repeat (7) @(negedge clk);
    chk(val == held, "R6 value held while idle", val, held);

    // R2: zero seed replaced by default
    load(32'h0, 1'b0);
    roll("R2 zero seed", 1'b0);
    load(32'h1234_5678, 1'b0);
    roll("R2 explicit seed", 1'b0);

    // R7: request during a roll is ignored
    roll("R7 extra request", 1'b1);

    // R8: load and request on the same edge
    load(32'hDEAD_BEEF, 1'b1);
    quiet(8, "R8 request dropped on load");
    roll("R8 after collision", 1'b0);

    // R8: load part-way through a draw
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
    load(32'h0F0F_3C3C, 1'b0);
    quiet(6, "R8 draw cancelled");
    roll("R8 after cancel", 1'b0);

    // Random mix: seeds, idle gaps, extra requests
    for (int it = 0; it < 90; it++) begin
      if ($urandom_range(3) == 0) load($urandom, 1'b0);
      repeat ($urandom_range(5)) @(negedge clk);
      roll("R1 random", $urandom_range(3) == 0);
    end

    chk(hist[0] == 0 && hist[7] == 0, "R3 faces 0 and 7 never shown", hist[0] + hist[7], 0);
    for (int f = 1; f <= 6; f++)
      chk(hist[f] > 0, "R3 every face reached", hist[f], 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule